// File: doc/BRIEF.md
# Locality Claim and Release Sequencer

This block claims and gives back the lowest-numbered locality of a memory-mapped trusted security module. It is the bus master for that job: it drives a simple register bus with a request/acknowledge handshake into the locality's register window. Two registers of the window are used. The access register sits at offset 0x00 and the status register at offset 0x18, both relative to a base address parameter.

A one-cycle `open_i` pulse starts the claim sequence. The block writes a use request to the access register. It then reads the access register until the active bit shows the grant, and finally writes the command-ready value to the status register. A one-cycle `close_i` pulse starts the release sequence. The block reads the access register first. If the locality is active, it writes the relinquish value and reads again until the active bit drops; if the locality is not active, it ends at once.

Each sequence ends with a one-cycle `done_o` pulse. If a polling loop runs past a parameterised number of cycles, `timeout_o` is raised together with `done_o`.

Top module: `loc_handshake_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `timeout_o` and `bus_req_o` are all 0.
- R2: An open sequence starts with exactly one write of 0x0000_0002 (bit 1, request use) to address BASE+0x00.
- R3: After that write, an open sequence reads BASE+0x00 over and over until a read returns bit 5 (active) as 1. With no timeout, the number of reads equals the number of inactive replies plus one.
- R4: Once bit 5 reads as 1, the open sequence writes 0x0000_0040 (bit 6, command ready) once to BASE+0x18. It then pulses `done_o` with `timeout_o` at 0.
- R5: A read of the open poll ends the sequence with `done_o` and `timeout_o` both high, and with no status write, when all of the following hold: it returns bit 5 as 0, it completes while the block's poll cycle count is at least TIMEOUT_CYC, and the count started at 0 on the first polling cycle. A read that returns bit 5 as 1 counts as success even at that count.
- R6: A close sequence first reads BASE+0x00 once. If bit 5 is 0, it pulses `done_o` with `timeout_o` at 0 and makes no write.
- R7: If the first read of a close sequence shows bit 5 as 1, the sequence writes 0x0000_0020 to BASE+0x00. It then reads BASE+0x00 until bit 5 is 0 and pulses `done_o` with `timeout_o` at 0.
- R8: The close poll times out by the same rule as R5. The sequence then ends with `done_o` and `timeout_o` high.
- R9: `open_i` and `close_i` are ignored while `busy_o` is 1. If both are high in the same idle cycle, the open sequence runs.
- R10: Once `bus_req_o` is raised, it and `bus_we_o`, `bus_addr_o` and `bus_wdata_o` hold steady until a cycle in which `bus_ack_i` is 1. Each cycle with both high completes one transfer, and `bus_rdata_i` is taken in that same cycle.
- R11: `done_o` is high for exactly one cycle, and `busy_o` is 0 in that cycle. `timeout_o` is never high without `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| open_i | input | 1 | Pulse: claim the locality |
| close_i | input | 1 | Pulse: release the locality |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| timeout_o | output | 1 | Sequence ended by poll timeout (valid with done_o) |
| bus_req_o | output | 1 | Bus transfer request, held until acknowledged |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_ack_i | input | 1 | Transfer completes in this cycle |
| bus_rdata_i | input | DATA_W | Read data, valid with bus_ack_i |

## Verification
The hardest case to reach from the ports is the timeout boundary. There, the outcome depends on whether the reply that arrives exactly as the poll count reaches its limit shows the grant. It is made harder when acknowledgements are stalled, so poll reads land only every few cycles. The bench drives a register model of the device with a settable number of inactive replies, a "never" setting and a settable acknowledge latency. With these it places the last read on both sides of the limit, and checks the read counts it predicts from the latency against those the model saw.

// File: rtl/loc_pkg.sv
package loc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN_REQ,
        ST_OPEN_POLL,
        ST_OPEN_RDY,
        ST_CLOSE_CHK,
        ST_CLOSE_REL,
        ST_CLOSE_POLL
    } loc_state_e;

    typedef struct packed {
        loc_state_e state;
        logic       done;
        logic       err;
    } loc_regs_t;

    // Register offsets inside the locality window
    localparam int unsigned ACC_OFS = 32'h00;
    localparam int unsigned STS_OFS = 32'h18;

    // Bit positions the device decodes
    localparam int unsigned BIT_REQ_USE = 1;
    localparam int unsigned BIT_ACTIVE  = 5;
    localparam int unsigned BIT_CMD_RDY = 6;

endpackage

// File: rtl/loc_poll_timer.sv
module loc_poll_timer #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q == LIMIT_C) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == LIMIT_C);

    // R5/R8: once expired, stays expired while polling continues
    p_expire_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && run_i) |=> expired_o);

endmodule

// File: rtl/loc_bus_decode.sv
module loc_bus_decode
    import loc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned BASE_ADDR = 0
) (
    input  loc_state_e        state_i,
    output logic              req_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);
    localparam logic [ADDR_W-1:0] ACC_A = ADDR_W'(BASE_ADDR + ACC_OFS);
    localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(BASE_ADDR + STS_OFS);
    localparam logic [DATA_W-1:0] V_REQ = DATA_W'(1) << BIT_REQ_USE;
    localparam logic [DATA_W-1:0] V_REL = DATA_W'(1) << BIT_ACTIVE;
    localparam logic [DATA_W-1:0] V_RDY = DATA_W'(1) << BIT_CMD_RDY;

    always_comb begin
        req_o   = 1'b1;
        we_o    = 1'b0;
        addr_o  = ACC_A;
        wdata_o = '0;
        unique case (state_i)
            ST_IDLE:       req_o = 1'b0;
            ST_OPEN_REQ:   begin we_o = 1'b1; wdata_o = V_REQ; end
            ST_OPEN_POLL:  ;
            ST_OPEN_RDY:   begin we_o = 1'b1; addr_o = STS_A; wdata_o = V_RDY; end
            ST_CLOSE_CHK:  ;
            ST_CLOSE_REL:  begin we_o = 1'b1; wdata_o = V_REL; end
            ST_CLOSE_POLL: ;
            default:       req_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/loc_handshake_ctrl.sv
module loc_handshake_ctrl
    import loc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned BASE_ADDR   = 0,
    parameter int unsigned TIMEOUT_CYC = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_i,
    input  logic              close_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [DATA_W-1:0] bus_rdata_i
);
    localparam logic [DATA_W-1:0] ACT_MASK = DATA_W'(1) << BIT_ACTIVE;
    localparam logic [ADDR_W-1:0] ACC_A    = ADDR_W'(BASE_ADDR + ACC_OFS);
    localparam logic [DATA_W-1:0] V_REQ    = DATA_W'(1) << BIT_REQ_USE;

    loc_regs_t r_d, r_q;
    logic      xfer;
    logic      active;
    logic      polling;
    logic      expired;

    assign xfer    = bus_req_o && bus_ack_i;
    assign active  = |(bus_rdata_i & ACT_MASK);
    assign polling = (r_q.state == ST_OPEN_POLL) || (r_q.state == ST_CLOSE_POLL);

    loc_poll_timer #(
        .LIMIT (TIMEOUT_CYC)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (polling),
        .expired_o (expired)
    );

    loc_bus_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BASE_ADDR (BASE_ADDR)
    ) i_decode (
        .state_i (r_q.state),
        .req_o   (bus_req_o),
        .we_o    (bus_we_o),
        .addr_o  (bus_addr_o),
        .wdata_o (bus_wdata_o)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (open_i) begin
                    r_d.state = ST_OPEN_REQ;
                end else if (close_i) begin
                    r_d.state = ST_CLOSE_CHK;
                end
            end
            ST_OPEN_REQ: begin
                if (xfer) r_d.state = ST_OPEN_POLL;
            end
            ST_OPEN_POLL: begin
                if (xfer) begin
                    if (active) begin
                        r_d.state = ST_OPEN_RDY;
                    end else if (expired) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b1;
                    end
                end
            end
            ST_OPEN_RDY: begin
                if (xfer) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            ST_CLOSE_CHK: begin
                if (xfer) begin
                    if (active) begin
                        r_d.state = ST_CLOSE_REL;
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end
                end
            end
            ST_CLOSE_REL: begin
                if (xfer) r_d.state = ST_CLOSE_POLL;
            end
            ST_CLOSE_POLL: begin
                if (xfer) begin
                    if (!active) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else if (expired) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = (r_q.state != ST_IDLE);
    assign done_o    = r_q.done;
    assign timeout_o = r_q.err;

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o)
            && $stable(bus_we_o) && $stable(bus_wdata_o)));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> done_o);

    p_open_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && open_i) |=> (bus_req_o && bus_we_o
            && bus_addr_o == ACC_A && bus_wdata_o == V_REQ));

    p_close_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && close_i && !open_i) |=> (bus_req_o && !bus_we_o
            && bus_addr_o == ACC_A));

endmodule

// File: tb/test_loc_handshake_ctrl.sv
`timescale 1ns/1ps
module test_loc_handshake_ctrl;

    localparam int T = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        open_i = 1'b0;
    logic        close_i = 1'b0;
    logic        busy_o, done_o, timeout_o;
    logic        bus_req, bus_we, bus_ack;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    always #4 clk = ~clk;

    loc_handshake_ctrl #(
        .ADDR_W (16), .DATA_W (32), .BASE_ADDR (0), .TIMEOUT_CYC (T)
    ) i_loc_handshake_ctrl (
        .clk (clk), .rst_n (rst_n), .open_i (open_i), .close_i (close_i),
        .busy_o (busy_o), .done_o (done_o), .timeout_o (timeout_o),
        .bus_req_o (bus_req), .bus_we_o (bus_we), .bus_addr_o (bus_addr),
        .bus_wdata_o (bus_wdata), .bus_ack_i (bus_ack), .bus_rdata_i (bus_rdata)
    );

    // Device register model
    int          dly_cfg = 0, lat_cfg = 0, wcnt_q = 0, left_q = 0;
    int          acc_wr = 0, sts_wr = 0, acc_rd = 0, viol = 0;
    logic        act_q = 1'b0, pend_q = 1'b0, pend_val_q = 1'b0;
    logic [31:0] last_acc = '0, last_sts = '0;
    logic        clr_req = 1'b0, load_req = 1'b0, load_val = 1'b0;
    logic        pv_pend = 1'b0, pv_we = 1'b0;
    logic [15:0] pv_addr = '0;
    logic [31:0] pv_wdata = '0;
    logic        cur_act;

    assign bus_ack   = bus_req && (wcnt_q >= lat_cfg);
    assign cur_act   = (pend_q && left_q == 0) ? pend_val_q : act_q;
    assign bus_rdata = {26'b0, cur_act, 5'b0};

    always @(posedge clk) begin
        wcnt_q <= (bus_req && !bus_ack) ? wcnt_q + 1 : 0;
        // R10 monitor: request fields held until acknowledge
        if (pv_pend && !(bus_req && bus_addr == pv_addr && bus_we == pv_we
                         && bus_wdata == pv_wdata)) viol <= viol + 1;
        pv_pend  <= bus_req && !bus_ack;
        pv_addr  <= bus_addr;
        pv_we    <= bus_we;
        pv_wdata <= bus_wdata;
        if (clr_req) begin
            acc_wr <= 0; sts_wr <= 0; acc_rd <= 0;
        end
        if (load_req) begin
            act_q  <= load_val;
            pend_q <= 1'b0;
        end else if (bus_req && bus_ack) begin
            if (bus_we) begin
                if (bus_addr == 16'h0000) begin
                    acc_wr     <= acc_wr + 1;
                    last_acc   <= bus_wdata;
                    pend_q     <= 1'b1;
                    left_q     <= dly_cfg;
                    pend_val_q <= (bus_wdata == 32'h2);
                end else if (bus_addr == 16'h0018) begin
                    sts_wr   <= sts_wr + 1;
                    last_sts <= bus_wdata;
                end
            end else if (bus_addr == 16'h0000) begin
                acc_rd <= acc_rd + 1;
                if (pend_q) begin
                    if (left_q == 0) begin
                        act_q  <= pend_val_q;
                        pend_q <= 1'b0;
                    end else if (left_q != 255) begin
                        left_q <= left_q - 1;
                    end
                end
            end
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            report();
        end
    end

    task automatic load_act(input logic v);
        @(negedge clk); load_req = 1'b1; load_val = v;
        @(negedge clk); load_req = 1'b0;
    endtask

    task automatic run_op(input bit both, input bit cls, input int dly, input int lat,
                          output bit err);
        @(negedge clk); dly_cfg = dly; lat_cfg = lat; clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
        open_i  = both || !cls;
        close_i = both || cls;
        @(negedge clk); open_i = 1'b0; close_i = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (done_o) break;
            @(negedge clk);
        end
        chk("R11", "done seen", done_o, 1);
        chk("R11", "busy low with done", busy_o, 0);
        err = timeout_o;
        @(negedge clk);
        chk("R11", "done one cycle", done_o, 0);
        chk("R11", "timeout without done", timeout_o, 0);
    endtask

    function automatic int kfail(input int lat);
        for (int k = 0; k < 1000; k++) if (k * (lat + 1) + lat >= T) return k;
        return -1;
    endfunction

    typedef struct packed {
        logic       cls;
        logic       act;
        logic [7:0] dly;
        logic [3:0] lat;
        logic       err;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'd0,   4'd0, 1'b0},
        '{1'b0, 1'b0, 8'd3,   4'd0, 1'b0},
        '{1'b0, 1'b0, 8'd5,   4'd2, 1'b0},
        '{1'b0, 1'b0, 8'd255, 4'd0, 1'b1},
        '{1'b0, 1'b0, 8'd255, 4'd2, 1'b1},
        '{1'b0, 1'b0, 8'd20,  4'd0, 1'b0},
        '{1'b0, 1'b0, 8'd21,  4'd0, 1'b1},
        '{1'b1, 1'b1, 8'd0,   4'd0, 1'b0},
        '{1'b1, 1'b1, 8'd4,   4'd1, 1'b0},
        '{1'b1, 1'b0, 8'd0,   4'd0, 1'b0},
        '{1'b1, 1'b1, 8'd255, 4'd0, 1'b1}
    };

    initial begin
        bit err;
        int polls;
        int req_seen;
        // R1: reset state
        @(negedge clk);
        chk("R1", "busy", busy_o, 0);
        chk("R1", "done", done_o, 0);
        chk("R1", "timeout", timeout_o, 0);
        chk("R1", "bus_req", bus_req, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "bus_req after release", bus_req, 0);

        for (int v = 0; v < NV; v++) begin
            load_act(VECS[v].act);
            run_op(1'b0, VECS[v].cls, int'(VECS[v].dly), int'(VECS[v].lat), err);
            polls = VECS[v].err ? kfail(int'(VECS[v].lat)) + 1 : int'(VECS[v].dly) + 1;
            if (!VECS[v].cls) begin
                chk("R2", "access writes", acc_wr, 1);
                chk("R2", "request value", int'(last_acc), 32'h2);
                chk(VECS[v].err ? "R5" : "R3", "poll reads", acc_rd, polls);
                chk(VECS[v].err ? "R5" : "R4", "timeout flag", err, VECS[v].err);
                chk(VECS[v].err ? "R5" : "R4", "status writes", sts_wr, VECS[v].err ? 0 : 1);
                if (!VECS[v].err) chk("R4", "status value", int'(last_sts), 32'h40);
            end else if (!VECS[v].act) begin
                chk("R6", "reads", acc_rd, 1);
                chk("R6", "writes", acc_wr + sts_wr, 0);
                chk("R6", "timeout flag", err, 0);
            end else begin
                chk("R7", "release writes", acc_wr, 1);
                chk("R7", "release value", int'(last_acc), 32'h20);
                chk(VECS[v].err ? "R8" : "R7", "reads", acc_rd, 1 + polls);
                chk(VECS[v].err ? "R8" : "R7", "timeout flag", err, VECS[v].err);
                chk("R7", "status writes", sts_wr, 0);
            end
        end

        // R9: pulses while busy are ignored
        load_act(1'b0);
        @(negedge clk); dly_cfg = 5; lat_cfg = 0; clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0; open_i = 1'b1;
        @(negedge clk); open_i = 1'b1; close_i = 1'b1;
        chk("R9", "busy during open", busy_o, 1);
        @(negedge clk); open_i = 1'b0; close_i = 1'b1;
        @(negedge clk); close_i = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done_o) break;
            @(negedge clk);
        end
        req_seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (bus_req) req_seen++;
        end
        chk("R9", "bus quiet after done", req_seen, 0);
        chk("R9", "access writes", acc_wr, 1);
        chk("R9", "reads", acc_rd, 6);
        chk("R9", "status writes", sts_wr, 1);

        // R9: open wins over close in the same idle cycle
        load_act(1'b0);
        run_op(1'b1, 1'b0, 0, 0, err);
        chk("R9", "open priority value", int'(last_acc), 32'h2);
        chk("R9", "open priority status", sts_wr, 1);

        // R10: request hold under stalled acknowledge seen above
        chk("R10", "request fields changed before ack", viol, 0);
        report();
    end

endmodule